// File: doc/BRIEF.md
# CAS Latency 2 Feasibility Checker

This block decides whether a memory device can be run at a CAS latency of two clocks for a given operating clock period, even when the device does not list latency two among its supported settings. The device reports up to three supported latencies as a 3-bit map anchored at its highest latency X, with a minimum cycle time for each of the three positions. The block multiplies each supported latency by its cycle time and takes the smallest product as the device's fundamental access time. Half of that time, rounded up, is the shortest clock period that latency two can tolerate. The operating period is then compared against it.

All times are unsigned integers in picoseconds. A request is presented with a one-cycle valid strobe. The results come back two clock cycles later and are held until the next request. Decoding the raw device description bytes happens upstream and is not part of this block.

Top module: `cl2_feasibility_check`

## Requirements
- R1: Map bit 2 stands for latency X (`lat_top`) with cycle time `tck_top`. Bit 1 stands for X-1 with `tck_next`. Bit 0 stands for X-2 with `tck_third`.
- R2: `access_time` is the smallest latency-times-cycle-time product over all supported positions.
- R3: A position is left out of the minimum when its map bit is clear or when its latency would be below 1. Its cycle time then has no effect on any output.
- R4: `min_cl2_period` is `access_time` divided by two and rounded up.
- R5: When latency two is not among the supported positions and at least one position is supported, `cl2_ok` is 1 exactly when `clk_period` >= `min_cl2_period`.
- R6: When a supported position has latency exactly 2, `cl2_ok` is 1 whatever the value of `clk_period`.
- R7: When no position is supported, `cl2_ok`, `access_time` and `min_cl2_period` are all 0.
- R8: A request sampled with `in_valid` high at a rising edge shows up, with `out_valid` high for one cycle, after the second rising edge that follows. The outputs keep their values until the next result arrives.
- R9: While `rst_n` is low at a rising edge, `out_valid`, `cl2_ok`, `access_time` and `min_cl2_period` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle request strobe |
| lat_map | input | 3 | Supported-latency map (bit 2 = X, bit 1 = X-1, bit 0 = X-2) |
| lat_top | input | LAT_W | Highest supported latency X, in clocks |
| tck_top | input | TIME_W | Minimum cycle time at X, ps |
| tck_next | input | TIME_W | Minimum cycle time at X-1, ps |
| tck_third | input | TIME_W | Minimum cycle time at X-2, ps |
| clk_period | input | TIME_W | Operating clock period, ps |
| out_valid | output | 1 | Result strobe |
| access_time | output | LAT_W+TIME_W | Fundamental access time, ps |
| min_cl2_period | output | LAT_W+TIME_W | Shortest period allowed at latency two, ps |
| cl2_ok | output | 1 | Latency two is feasible |

## Verification
The stimulus set has three groups. Full maps whose products tie test selection of the minimum across positions. Maps in which a middle or lowest position gives the smallest product show that the minimum is not taken from the top latency. Single-bit maps that carry a small decoy cycle time on a cleared position show that cleared positions are excluded. Periods set exactly at the threshold and one picosecond below it separate `>=` from `>`. Odd access times show whether the halving rounds up. Maps where latency two appears, paired with the same map with that bit cleared, separate the direct pass from the computed check. Values of X below 3 test the rule that drops latencies under 1. A maximum-width case tests that the products do not overflow.

// File: rtl/cl2_pkg.sv
`timescale 1ns/1ps
// Package cl2_pkg: shared constants and position names for the CL2 checker.
// Assumes exactly three latency positions, anchored at the top latency X.
package cl2_pkg;
    // Number of latency positions in the supported-latency map
    localparam int POS_COUNT = 3;

    // Map bit index of each position; the distance from X is POS_COUNT-1-index
    typedef enum logic [1:0] {
        POS_THIRD = 2'd0,
        POS_NEXT  = 2'd1,
        POS_TOP   = 2'd2
    } pos_e;
endpackage

// File: rtl/cl2_lane.sv
`timescale 1ns/1ps
// Module cl2_lane: one latency position. It works out the latency X-OFFSET,
// whether the position takes part (its map bit is set and the latency is at
// least 1), whether that latency is exactly two, and the latency-times-cycle
// product. The block is purely combinational. The product is zero for a
// position that does not take part.
module cl2_lane #(
    parameter int LAT_W  = 4,
    parameter int TIME_W = 16,
    parameter int OFFSET = 0,
    localparam int PROD_W = LAT_W + TIME_W
) (
    input  logic [LAT_W-1:0]  lat_top,
    input  logic              bit_set,
    input  logic [TIME_W-1:0] tck,
    output logic              en,
    output logic              is_cl2,
    output logic [PROD_W-1:0] product
);
    localparam logic [LAT_W-1:0] OFF_V = LAT_W'(OFFSET);
    localparam logic [LAT_W-1:0] TWO_V = LAT_W'(2);

    logic [LAT_W-1:0] lat;

    // Latency of this position, whether it takes part, and its product
    always_comb begin
        lat     = lat_top - OFF_V;
        en      = bit_set && (lat_top > OFF_V);
        is_cl2  = en && (lat == TWO_V);
        product = en ? (PROD_W'(lat) * PROD_W'(tck)) : '0;
    end
endmodule

// File: rtl/cl2_min_reduce.sv
`timescale 1ns/1ps
// Module cl2_min_reduce: finds the minimum over the enabled lanes of a flat
// vector of products. `any` shows whether at least one lane is enabled.
// When no lane is enabled the minimum is zero. Combinational.
module cl2_min_reduce #(
    parameter int N = 3,
    parameter int W = 20
) (
    input  logic [N-1:0]   en,
    input  logic [N*W-1:0] prods,
    output logic           any,
    output logic [W-1:0]   minv
);
    // Linear scan that keeps the smallest enabled product
    always_comb begin
        any  = 1'b0;
        minv = '0;
        for (int i = 0; i < N; i++) begin
            if (en[i] && (!any || (prods[i*W +: W] < minv))) begin
                minv = prods[i*W +: W];
            end
            if (en[i]) begin
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cl2_verdict.sv
`timescale 1ns/1ps
// Module cl2_verdict: halves the access time with upward rounding, so the
// block never passes a case it should fail. It then decides feasibility:
// a direct pass when latency two is already supported, otherwise a
// comparison of the period against the limit. With no supported lane the
// verdict is always fail. Combinational.
module cl2_verdict #(
    parameter int ACC_W  = 20,
    parameter int TIME_W = 16
) (
    input  logic              any,
    input  logic              direct,
    input  logic [ACC_W-1:0]  access,
    input  logic [TIME_W-1:0] period,
    output logic [ACC_W-1:0]  min_cl2,
    output logic              pass
);
    localparam int PAD_W = ACC_W - TIME_W;

    logic [ACC_W:0]   rounded;
    logic [ACC_W-1:0] period_ext;

    // Ceiling of access/2, then the pass decision
    always_comb begin
        rounded    = {1'b0, access} + (ACC_W+1)'(1);
        min_cl2    = rounded[ACC_W:1];
        period_ext = {{PAD_W{1'b0}}, period};
        pass       = any && (direct || (period_ext >= min_cl2));
    end
endmodule

// File: rtl/cl2_feasibility_check.sv
`timescale 1ns/1ps
// Module cl2_feasibility_check: a two-stage pipeline that decides whether a
// device can run at CAS latency two. Stage 1 registers the per-position
// products, the enables, the direct-pass flag and the period. Stage 2 takes
// the minimum, halves it and registers the verdict. Assumes lat_map bit 2
// is X, bit 1 is X-1 and bit 0 is X-2, and that all times are in ps.
module cl2_feasibility_check
    import cl2_pkg::*;
#(
    parameter int LAT_W  = 4,
    parameter int TIME_W = 16,
    localparam int PROD_W = LAT_W + TIME_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [POS_COUNT-1:0] lat_map,
    input  logic [LAT_W-1:0]     lat_top,
    input  logic [TIME_W-1:0]    tck_top,
    input  logic [TIME_W-1:0]    tck_next,
    input  logic [TIME_W-1:0]    tck_third,
    input  logic [TIME_W-1:0]    clk_period,
    output logic                 out_valid,
    output logic [PROD_W-1:0]    access_time,
    output logic [PROD_W-1:0]    min_cl2_period,
    output logic                 cl2_ok
);
    logic [POS_COUNT*TIME_W-1:0] tck_all;
    logic [POS_COUNT-1:0]        lane_en;
    logic [POS_COUNT-1:0]        lane_cl2;
    logic [POS_COUNT*PROD_W-1:0] lane_prod;

    logic                        s1_valid;
    logic [POS_COUNT-1:0]        s1_en;
    logic [POS_COUNT*PROD_W-1:0] s1_prod;
    logic                        s1_direct;
    logic [TIME_W-1:0]           s1_period;

    logic                        red_any;
    logic [PROD_W-1:0]           red_min;
    logic [PROD_W-1:0]           ver_min;
    logic                        ver_pass;

    logic                        s2_direct;
    logic [TIME_W-1:0]           s2_period;

    // Order the cycle times by map bit index
    always_comb begin
        tck_all = '0;
        tck_all[POS_THIRD*TIME_W +: TIME_W] = tck_third;
        tck_all[POS_NEXT*TIME_W  +: TIME_W] = tck_next;
        tck_all[POS_TOP*TIME_W   +: TIME_W] = tck_top;
    end

    for (genvar g = 0; g < POS_COUNT; g++) begin : g_lane
        cl2_lane #(
            .LAT_W (LAT_W),
            .TIME_W(TIME_W),
            .OFFSET(POS_COUNT - 1 - g)
        ) i_lane (
            .lat_top(lat_top),
            .bit_set(lat_map[g]),
            .tck    (tck_all[g*TIME_W +: TIME_W]),
            .en     (lane_en[g]),
            .is_cl2 (lane_cl2[g]),
            .product(lane_prod[g*PROD_W +: PROD_W])
        );
    end

    // Stage 1: capture the lane results for a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_en     <= '0;
            s1_prod   <= '0;
            s1_direct <= 1'b0;
            s1_period <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_en     <= lane_en;
                s1_prod   <= lane_prod;
                s1_direct <= |lane_cl2;
                s1_period <= clk_period;
            end
        end
    end

    cl2_min_reduce #(
        .N(POS_COUNT),
        .W(PROD_W)
    ) i_reduce (
        .en   (s1_en),
        .prods(s1_prod),
        .any  (red_any),
        .minv (red_min)
    );

    cl2_verdict #(
        .ACC_W (PROD_W),
        .TIME_W(TIME_W)
    ) i_verdict (
        .any    (red_any),
        .direct (s1_direct),
        .access (red_min),
        .period (s1_period),
        .min_cl2(ver_min),
        .pass   (ver_pass)
    );

    // Stage 2: register the verdict and hold it until the next result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            access_time    <= '0;
            min_cl2_period <= '0;
            cl2_ok         <= 1'b0;
            s2_direct      <= 1'b0;
            s2_period      <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                access_time    <= red_min;
                min_cl2_period <= ver_min;
                cl2_ok         <= ver_pass;
                s2_direct      <= s1_direct;
                s2_period      <= s1_period;
            end
        end
    end

    // R8
    result_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(access_time) && $stable(cl2_ok) && $stable(min_cl2_period)));

    // R7
    empty_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_en == '0)) |=> (!cl2_ok && (access_time == '0)));

    // R5
    pass_basis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cl2_ok) |-> (s2_direct || ({{LAT_W{1'b0}}, s2_period} >= min_cl2_period)));

    // R4
    ceil_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (({1'b0, min_cl2_period} << 1) >= {1'b0, access_time}
                       && ({1'b0, min_cl2_period} << 1) <= ({1'b0, access_time} + 1'b1)));

    for (genvar k = 0; k < POS_COUNT; k++) begin : g_min_chk
        // R2
        min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_valid && s1_en[k]) |-> (red_min <= s1_prod[k*PROD_W +: PROD_W]));
    end
endmodule

// File: tb/test_cl2_feasibility_check.sv
`timescale 1ns/1ps
// Bench for cl2_feasibility_check: a vector table walked by one loop,
// followed by directed tests of reset, timing and hold.
module test_cl2_feasibility_check;
    localparam int LAT_W  = 4;
    localparam int TIME_W = 16;
    localparam int PROD_W = LAT_W + TIME_W;
    localparam int NV     = 13;

    // map, X, tck_top, tck_next, tck_third, period, exp access, exp min, exp pass
    localparam int V_MAP[NV] = '{7, 7, 7, 4, 1, 2, 7, 7, 6, 0, 3, 7, 4};
    localparam int V_X  [NV] = '{5, 5, 5, 3, 5, 6, 6, 4, 4, 5, 1, 2, 15};
    localparam int V_T2 [NV] = '{3000, 3000, 2400, 3333, 1000, 900, 2500, 2500, 2500, 3000, 100, 4000, 65535};
    localparam int V_T1 [NV] = '{3750, 3750, 3000, 900, 900, 2500, 2800, 3000, 3000, 3000, 100, 5000, 100};
    localparam int V_T0 [NV] = '{5000, 5000, 4000, 900, 5001, 900, 4000, 4000, 4000, 3000, 100, 100, 100};
    localparam int V_P  [NV] = '{7500, 7499, 6000, 4999, 7502, 7000, 6999, 1000, 1000, 9000, 9000, 100, 65535};
    localparam int V_ACC[NV] = '{15000, 15000, 12000, 9999, 15003, 12500, 14000, 8000, 9000, 0, 0, 5000, 983025};
    localparam int V_MIN[NV] = '{7500, 7500, 6000, 5000, 7502, 6250, 7000, 4000, 4500, 0, 0, 2500, 491513};
    localparam int V_OK [NV] = '{1, 0, 1, 0, 1, 1, 0, 1, 0, 0, 0, 1, 0};
    localparam string V_REQ[NV] = '{"R2", "R5", "R5", "R4", "R3", "R1", "R2", "R6", "R6", "R7", "R3", "R6", "R4"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [2:0]        lat_map = '0;
    logic [LAT_W-1:0]  lat_top = '0;
    logic [TIME_W-1:0] tck_top = '0;
    logic [TIME_W-1:0] tck_next = '0;
    logic [TIME_W-1:0] tck_third = '0;
    logic [TIME_W-1:0] clk_period = '0;
    logic              out_valid;
    logic [PROD_W-1:0] access_time;
    logic [PROD_W-1:0] min_cl2_period;
    logic              cl2_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cl2_feasibility_check #(.LAT_W(LAT_W), .TIME_W(TIME_W)) i_cl2_feasibility_check (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lat_map(lat_map),
        .lat_top(lat_top), .tck_top(tck_top), .tck_next(tck_next),
        .tck_third(tck_third), .clk_period(clk_period), .out_valid(out_valid),
        .access_time(access_time), .min_cl2_period(min_cl2_period), .cl2_ok(cl2_ok)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int m, input int x, input int t2, input int t1, input int t0, input int p);
        lat_map    = 3'(m);
        lat_top    = LAT_W'(x);
        tck_top    = TIME_W'(t2);
        tck_next   = TIME_W'(t1);
        tck_third  = TIME_W'(t0);
        clk_period = TIME_W'(p);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "out_valid in reset", out_valid, 0);
        check("R9", "cl2_ok in reset", cl2_ok, 0);
        check("R9", "access in reset", access_time, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: drive one request, sample two rising edges later
        for (int i = 0; i < NV; i++) begin
            drive(V_MAP[i], V_X[i], V_T2[i], V_T1[i], V_T0[i], V_P[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check("R8", $sformatf("vec %0d out_valid", i), out_valid, 1);
            check(V_REQ[i], $sformatf("vec %0d access", i), access_time, V_ACC[i]);
            check("R4", $sformatf("vec %0d min period", i), min_cl2_period, V_MIN[i]);
            check(V_REQ[i], $sformatf("vec %0d pass", i), cl2_ok, V_OK[i]);
        end

        // R8: timing of a single request and holding of the result
        @(negedge clk);
        check("R8", "out_valid idle", out_valid, 0);
        drive(7, 5, 3000, 3750, 5000, 7500);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "out_valid after one edge", out_valid, 0);
        drive(1, 5, 100, 100, 100, 100);
        @(negedge clk);
        check("R8", "out_valid after two edges", out_valid, 1);
        check("R8", "access after two edges", access_time, 15000);
        @(negedge clk);
        check("R8", "out_valid pulse ends", out_valid, 0);
        repeat (2) @(negedge clk);
        check("R8", "access held with new idle inputs", access_time, 15000);
        check("R8", "pass held", cl2_ok, 1);

        // R3: decoy on a cleared position has no effect
        drive(1, 5, 10, 10, 5001, 7502);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R3", "decoy cleared positions access", access_time, 15003);
        check("R3", "decoy cleared positions pass", cl2_ok, 1);

        // R9: reset after a result clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "access after reset", access_time, 0);
        check("R9", "pass after reset", cl2_ok, 0);
        check("R9", "min after reset", min_cl2_period, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule